// File: doc/BRIEF.md
# Video Controller Configuration Register File

This block is the processor-facing side of a raster video controller. An 8-bit bus master reaches it through one select pin and one register-select line. With register-select low, a write loads a small index register. With register-select high, the access goes to whichever control register that index points at. The control registers hold the horizontal and vertical timing counts, the scan mode, the cursor shape and blink mode, the display start address and the cursor address. Each of these drives an output port that the timing generator reads.

The block also holds a 14-bit light pen register. The timing generator supplies the live refresh address as an input. A rising edge on the pen strobe input, after synchronisation, latches that address plus a fixed offset of two characters. Software then reads the result back in two halves. Most registers are write-only. Only the cursor address and the light pen value can be read back.

Top module: `vid_cfg_regs`

## Requirements
- R1: While rst_ni is low, the index register, every configuration output and the light pen value are zero. After reset, reads of indexes 14 to 17 return 0.
- R2: While cs_ni is high, no register changes and rdata_oe_o is low, whatever the other bus inputs do.
- R3: A write with rs_i low loads wdata_i[4:0] into the 5-bit index register.
- R4: A write with rs_i high commits on the first rising clock edge at which en_i is sampled low after it was sampled high on the edge before, with cs_ni low and rw_i low. While en_i stays high, the written register keeps its old value.
- R5: Index to field mapping. Each field takes the low bits of wdata_i. 0 drives h_total_o[7:0]. 1 drives h_disp_o[7:0]. 2 drives h_sync_pos_o[7:0]. 3 drives sync_width_o[7:0]. 4 drives v_total_o[6:0]. 5 drives v_adjust_o[4:0]. 6 drives v_disp_o[6:0]. 7 drives v_sync_pos_o[6:0]. 8 drives scan_mode_o[1:0]. 9 drives max_raster_o[4:0]. 10 drives cursor_start_o from bits [4:0] and cursor_blink_o from bits [6:5]. 11 drives cursor_end_o[4:0].
- R6: A 14-bit address is split across two indexes. The high index takes wdata_i[5:0] into bits [13:8], and the low index takes wdata_i[7:0] into bits [7:0]. Start address uses 12 (high) and 13 (low). Cursor address uses 14 (high) and 15 (low). Light pen uses 16 (high) and 17 (low).
- R7: rdata_oe_o is high exactly while cs_ni is low, rw_i is high and en_i is high. rdata_o is zero whenever rdata_oe_o is low.
- R8: A read with rs_i high returns the cursor address halves at indexes 14 and 15 and the light pen halves at 16 and 17, with high halves zero-extended. It returns zero for indexes 0 to 13 and 18 to 31. A read with rs_i low returns zero.
- R9: Writes to indexes 16 to 31 change no register.
- R10: The strobe lpen_stb_i passes through two synchronising flip-flops. The third rising clock edge after it is first sampled high stores (refresh_addr_i + 2) mod 2^14 in the light pen register, with refresh_addr_i sampled at that edge.
- R11: Holding lpen_stb_i high causes no further capture. Only a new low-to-high transition captures again.
- R12: The capture offset wraps: refresh address 0x3FFF stores 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rs_i | input | 1 | 0 = index register, 1 = control register |
| rw_i | input | 1 | 1 = read, 0 = write |
| en_i | input | 1 | Bus enable strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| rdata_oe_o | output | 1 | Read data drive enable |
| refresh_addr_i | input | 14 | Live refresh memory address |
| lpen_stb_i | input | 1 | Light pen strobe |
| h_total_o | output | 8 | Horizontal total |
| h_disp_o | output | 8 | Horizontal displayed |
| h_sync_pos_o | output | 8 | Horizontal sync position |
| sync_width_o | output | 8 | Sync width |
| v_total_o | output | 7 | Vertical total |
| v_adjust_o | output | 5 | Vertical raster adjust |
| v_disp_o | output | 7 | Vertical displayed rows |
| v_sync_pos_o | output | 7 | Vertical sync position |
| scan_mode_o | output | 2 | Interlace mode |
| max_raster_o | output | 5 | Maximum raster address |
| cursor_blink_o | output | 2 | Cursor blink mode |
| cursor_start_o | output | 5 | Cursor start raster |
| cursor_end_o | output | 5 | Cursor end raster |
| start_addr_o | output | 14 | Display start address |
| cursor_addr_o | output | 14 | Cursor address |

## Verification
A register write shows on its output port one clock edge after the edge at which the bench drops en_i. The bench drives en_i high at one falling clock edge and low at the next, then samples at the falling edge that follows the commit. Read data and rdata_oe_o are combinational from the bus pins and the stored state, so reads are sampled 1 ns after the bus pins change, with no clock edge in between. The light pen result is due at the third rising edge after the strobe rises. The bench reads it back through the bus after two edges, to confirm it has not yet changed, and again after the third edge.

// File: rtl/vid_cfg_pkg.sv
package vid_cfg_pkg;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 5;
  localparam int MA_W     = 14;
  localparam int HI_W     = MA_W - DATA_W;
  localparam int NUM_WR   = 16;
  localparam int IDX_ST_H = 12;
  localparam int IDX_ST_L = 13;
  localparam int IDX_CU_H = 14;
  localparam int IDX_CU_L = 15;
  localparam int IDX_LP_H = 16;
  localparam int IDX_LP_L = 17;

  // implemented bits of each writable register
  function automatic logic [DATA_W-1:0] reg_mask(input int idx);
    case (idx)
      0, 1, 2, 3, IDX_ST_L, IDX_CU_L: reg_mask = 8'hFF;
      4, 6, 7, 10:                    reg_mask = 8'h7F;
      5, 9, 11:                       reg_mask = 8'h1F;
      8:                              reg_mask = 8'h03;
      IDX_ST_H, IDX_CU_H:             reg_mask = DATA_W'((1 << HI_W) - 1);
      default:                        reg_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/vid_cfg_bus_if.sv
module vid_cfg_bus_if (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rs_i,
  input  logic rw_i,
  input  logic en_i,
  output logic wr_idx_o,
  output logic wr_reg_o,
  output logic rd_oe_o
);
  logic en_q, en_fall, wr_sel;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;

  assign en_fall  = en_q & ~en_i;
  assign wr_sel   = ~cs_ni & ~rw_i & en_fall;
  assign wr_idx_o = wr_sel & ~rs_i;
  assign wr_reg_o = wr_sel & rs_i;
  assign rd_oe_o  = ~cs_ni & rw_i & en_i;
endmodule

// File: rtl/vid_cfg_lpen.sv
module vid_cfg_lpen #(
  parameter int MA_W        = 14,
  parameter int SYNC_STAGES = 2,
  parameter int OFFSET      = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stb_i,
  input  logic [MA_W-1:0] addr_i,
  output logic [MA_W-1:0] lpen_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 rise;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], stb_i};

  assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   lpen_o <= '0;
    else if (rise) lpen_o <= addr_i + MA_W'(OFFSET);
endmodule

// File: rtl/vid_cfg_regs.sv
module vid_cfg_regs
  import vid_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LPEN_OFFSET = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            rs_i,
  input  logic            rw_i,
  input  logic            en_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  output logic            rdata_oe_o,
  input  logic [13:0]     refresh_addr_i,
  input  logic            lpen_stb_i,
  output logic [7:0]      h_total_o,
  output logic [7:0]      h_disp_o,
  output logic [7:0]      h_sync_pos_o,
  output logic [7:0]      sync_width_o,
  output logic [6:0]      v_total_o,
  output logic [4:0]      v_adjust_o,
  output logic [6:0]      v_disp_o,
  output logic [6:0]      v_sync_pos_o,
  output logic [1:0]      scan_mode_o,
  output logic [4:0]      max_raster_o,
  output logic [1:0]      cursor_blink_o,
  output logic [4:0]      cursor_start_o,
  output logic [4:0]      cursor_end_o,
  output logic [13:0]     start_addr_o,
  output logic [13:0]     cursor_addr_o
);
  logic              wr_idx, wr_reg, rd_oe;
  logic [IDX_W-1:0]  addr_q;
  logic [DATA_W-1:0] regs_q [NUM_WR];
  logic [MA_W-1:0]   lpen_q;
  logic [DATA_W-1:0] rd_mux;

  vid_cfg_bus_if u_bus (
    .clk_i, .rst_ni, .cs_ni, .rs_i, .rw_i, .en_i,
    .wr_idx_o(wr_idx), .wr_reg_o(wr_reg), .rd_oe_o(rd_oe)
  );

  vid_cfg_lpen #(.MA_W(MA_W), .SYNC_STAGES(SYNC_STAGES), .OFFSET(LPEN_OFFSET)) u_lpen (
    .clk_i, .rst_ni, .stb_i(lpen_stb_i), .addr_i(refresh_addr_i), .lpen_o(lpen_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     addr_q <= '0;
    else if (wr_idx) addr_q <= wdata_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WR; i++) regs_q[i] <= '0;
    end else if (wr_reg) begin
      for (int i = 0; i < NUM_WR; i++)
        if (addr_q == IDX_W'(i)) regs_q[i] <= wdata_i & reg_mask(i);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rs_i) begin
      case (int'(addr_q))
        IDX_CU_H: rd_mux = regs_q[IDX_CU_H];
        IDX_CU_L: rd_mux = regs_q[IDX_CU_L];
        IDX_LP_H: rd_mux = DATA_W'(lpen_q[MA_W-1:DATA_W]);
        IDX_LP_L: rd_mux = lpen_q[DATA_W-1:0];
        default:  rd_mux = '0;
      endcase
    end
  end

  assign rdata_oe_o = rd_oe;
  assign rdata_o    = rd_oe ? rd_mux : '0;

  assign h_total_o      = regs_q[0];
  assign h_disp_o       = regs_q[1];
  assign h_sync_pos_o   = regs_q[2];
  assign sync_width_o   = regs_q[3];
  assign v_total_o      = regs_q[4][6:0];
  assign v_adjust_o     = regs_q[5][4:0];
  assign v_disp_o       = regs_q[6][6:0];
  assign v_sync_pos_o   = regs_q[7][6:0];
  assign scan_mode_o    = regs_q[8][1:0];
  assign max_raster_o   = regs_q[9][4:0];
  assign cursor_blink_o = regs_q[10][6:5];
  assign cursor_start_o = regs_q[10][4:0];
  assign cursor_end_o   = regs_q[11][4:0];
  assign start_addr_o   = {regs_q[IDX_ST_H][HI_W-1:0], regs_q[IDX_ST_L]};
  assign cursor_addr_o  = {regs_q[IDX_CU_H][HI_W-1:0], regs_q[IDX_CU_L]};
endmodule

// File: rtl/vid_cfg_regs_chk.sv
module vid_cfg_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_ni,
  input logic        rs_i,
  input logic        rw_i,
  input logic        en_i,
  input logic [4:0]  addr_q,
  input logic [7:0]  rdata_o,
  input logic        rdata_oe_o,
  input logic [13:0] refresh_addr_i,
  input logic [13:0] lpen_q,
  input logic [7:0]  h_total_o
);
  logic en_prev;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_prev <= 1'b0;
    else         en_prev <= en_i;

  a_r2_idx_hold_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(addr_q));

  a_r2_no_drive_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !rdata_oe_o);

  a_r7_quiet_when_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> rdata_o == 8'h00);

  a_r8_write_only_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_oe_o && rs_i && addr_q < 5'd14) |-> rdata_o == 8'h00);

  a_r4_commit_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(h_total_o) |-> $past(!cs_ni && !rw_i && rs_i && en_prev && !en_i && addr_q == 5'd0));

  a_r10_capture_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lpen_q) |-> lpen_q == 14'($past(refresh_addr_i) + 14'd2));
endmodule

bind vid_cfg_regs vid_cfg_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rs_i(rs_i), .rw_i(rw_i), .en_i(en_i),
  .addr_q(addr_q), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o),
  .refresh_addr_i(refresh_addr_i), .lpen_q(lpen_q), .h_total_o(h_total_o)
);

// File: tb/vid_cfg_regs_test.sv
`timescale 1ns/1ps
module vid_cfg_regs_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rs_i = 1'b0, rw_i = 1'b1, en_i = 1'b0, lpen_stb_i = 1'b0;
  logic [7:0]  wdata_i = '0, rdata_o, h_total_o, h_disp_o, h_sync_pos_o, sync_width_o;
  logic        rdata_oe_o;
  logic [13:0] refresh_addr_i = '0, start_addr_o, cursor_addr_o;
  logic [6:0]  v_total_o, v_disp_o, v_sync_pos_o;
  logic [4:0]  v_adjust_o, max_raster_o, cursor_start_o, cursor_end_o;
  logic [1:0]  scan_mode_o, cursor_blink_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vid_cfg_regs uut (
    .clk_i(clk), .rst_ni, .cs_ni, .rs_i, .rw_i, .en_i, .wdata_i, .rdata_o, .rdata_oe_o,
    .refresh_addr_i, .lpen_stb_i, .h_total_o, .h_disp_o, .h_sync_pos_o, .sync_width_o,
    .v_total_o, .v_adjust_o, .v_disp_o, .v_sync_pos_o, .scan_mode_o, .max_raster_o,
    .cursor_blink_o, .cursor_start_o, .cursor_end_o, .start_addr_o, .cursor_addr_o
  );

  typedef struct packed { logic [4:0] idx; logic [7:0] data; } vec_t;
  localparam vec_t VECS [16] = '{
    '{5'd0, 8'hA5}, '{5'd1, 8'h50}, '{5'd2, 8'h5A}, '{5'd3, 8'hC3},
    '{5'd4, 8'hFF}, '{5'd5, 8'hEB}, '{5'd6, 8'h99}, '{5'd7, 8'hB3},
    '{5'd8, 8'hFE}, '{5'd9, 8'hE7}, '{5'd10, 8'hED}, '{5'd11, 8'h3C},
    '{5'd12, 8'hC1}, '{5'd13, 8'h23}, '{5'd14, 8'hFA}, '{5'd15, 8'h5C}};

  // field widths per R5/R6
  function automatic logic [7:0] mask_of(input int idx);
    case (idx)
      4, 6, 7, 10: mask_of = 8'h7F;
      5, 9, 11:    mask_of = 8'h1F;
      8:           mask_of = 8'h03;
      12, 14:      mask_of = 8'h3F;
      default:     mask_of = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] observe(input int idx);
    case (idx)
      0: observe = h_total_o;       1: observe = h_disp_o;
      2: observe = h_sync_pos_o;    3: observe = sync_width_o;
      4: observe = 8'(v_total_o);   5: observe = 8'(v_adjust_o);
      6: observe = 8'(v_disp_o);    7: observe = 8'(v_sync_pos_o);
      8: observe = 8'(scan_mode_o); 9: observe = 8'(max_raster_o);
      10: observe = {1'b0, cursor_blink_o, cursor_start_o};
      11: observe = 8'(cursor_end_o);
      12: observe = 8'(start_addr_o[13:8]); 13: observe = start_addr_o[7:0];
      14: observe = 8'(cursor_addr_o[13:8]); default: observe = cursor_addr_o[7:0];
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic rs, input logic [7:0] d);
    @(negedge clk); cs_ni = 1'b0; rs_i = rs; rw_i = 1'b0; wdata_i = d; en_i = 1'b1;
    @(negedge clk); en_i = 1'b0;
    @(negedge clk); cs_ni = 1'b1; rw_i = 1'b1;
  endtask

  task automatic bus_read(input logic rs, output logic [7:0] d, output logic oe);
    @(negedge clk); cs_ni = 1'b0; rs_i = rs; rw_i = 1'b1; en_i = 1'b1;
    #1 d = rdata_o; oe = rdata_oe_o;
    @(negedge clk); en_i = 1'b0; cs_ni = 1'b1;
  endtask

  task automatic read_reg(input logic [4:0] idx, output logic [7:0] d);
    logic oe;
    bus_write(1'b0, 8'(idx));
    bus_read(1'b1, d, oe);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    check("R1 reset h_total", 16'(h_total_o), 16'h0);
    check("R1 reset cursor_addr", 16'(cursor_addr_o), 16'h0);
    rst_ni = 1'b1;
    read_reg(5'd17, d);
    check("R1 lpen low after reset", 16'(d), 16'h0);

    // R5 R6 table walk
    foreach (VECS[k]) begin
      bus_write(1'b0, 8'(VECS[k].idx));
      bus_write(1'b1, VECS[k].data);
      check($sformatf("R5/R6 index %0d", VECS[k].idx), 16'(observe(int'(VECS[k].idx))),
            16'(VECS[k].data & mask_of(int'(VECS[k].idx))));
    end
    check("R6 start_addr", 16'(start_addr_o), 16'h0123);

    // R8 readback
    read_reg(5'd14, d); check("R8 cursor high read", 16'(d), 16'h003A);
    read_reg(5'd15, d); check("R8 cursor low read", 16'(d), 16'h005C);
    read_reg(5'd0, d);  check("R8 write-only reads zero", 16'(d), 16'h0);
    read_reg(5'd20, d); check("R8 unimplemented reads zero", 16'(d), 16'h0);
    bus_read(1'b0, d, oe);
    check("R8 index read zero", 16'(d), 16'h0);
    check("R7 oe during read", 16'(oe), 16'h1);
    #1 check("R7 oe idle", 16'(rdata_oe_o), 16'h0);
    check("R7 rdata idle zero", 16'(rdata_o), 16'h0);

    // R9 writes to 16, 17, 20 ignored
    bus_write(1'b0, 8'd16); bus_write(1'b1, 8'hFF);
    bus_write(1'b0, 8'd17); bus_write(1'b1, 8'hFF);
    bus_write(1'b0, 8'd20); bus_write(1'b1, 8'h77);
    read_reg(5'd16, d); check("R9 lpen high unwritten", 16'(d), 16'h0);
    read_reg(5'd17, d); check("R9 lpen low unwritten", 16'(d), 16'h0);
    check("R9 h_total untouched", 16'(h_total_o), 16'h00A5);
    check("R9 cursor untouched", 16'(cursor_addr_o), 16'h3A5C);

    // R3 index write then R2 deselected activity
    bus_write(1'b0, 8'hE0);
    read_reg(5'd14, d); check("R3 index low bits", 16'(d), 16'h003A);
    bus_write(1'b0, 8'd0);
    @(negedge clk); cs_ni = 1'b1; rs_i = 1'b1; rw_i = 1'b0; wdata_i = 8'h11; en_i = 1'b1;
    @(negedge clk); en_i = 1'b0;
    @(negedge clk); rw_i = 1'b1; en_i = 1'b1;
    #1 check("R2 no oe deselected", 16'(rdata_oe_o), 16'h0);
    check("R2 no write deselected", 16'(h_total_o), 16'h00A5);
    @(negedge clk); en_i = 1'b0;

    // R4 held enable: no commit until fall
    @(negedge clk); cs_ni = 1'b0; rs_i = 1'b1; rw_i = 1'b0; wdata_i = 8'h3E; en_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 no commit while enable high", 16'(h_total_o), 16'h00A5);
    en_i = 1'b0;
    @(negedge clk);
    check("R4 commit after fall", 16'(h_total_o), 16'h003E);
    cs_ni = 1'b1; rw_i = 1'b1;

    // R10 capture latency and value
    bus_write(1'b0, 8'd17);
    @(negedge clk); refresh_addr_i = 14'h1234; lpen_stb_i = 1'b1;
    @(negedge clk); @(negedge clk);
    cs_ni = 1'b0; rs_i = 1'b1; rw_i = 1'b1; en_i = 1'b1;
    #1 check("R10 not yet captured", 16'(rdata_o), 16'h0);
    @(negedge clk);
    #1 check("R10 captured low", 16'(rdata_o), 16'h0036);
    en_i = 1'b0; cs_ni = 1'b1;
    read_reg(5'd16, d); check("R10 captured high", 16'(d), 16'h0012);

    // R11 held strobe
    @(negedge clk); refresh_addr_i = 14'h0100;
    repeat (4) @(negedge clk);
    read_reg(5'd17, d); check("R11 no recapture", 16'(d), 16'h0036);

    // R12 wrap
    lpen_stb_i = 1'b0; refresh_addr_i = 14'h3FFF;
    repeat (4) @(negedge clk);
    lpen_stb_i = 1'b1;
    repeat (4) @(negedge clk);
    read_reg(5'd17, d); check("R12 wrap low", 16'(d), 16'h0001);
    read_reg(5'd16, d); check("R12 wrap high", 16'(d), 16'h0000);

    // R1 reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    #1 check("R1 reset clears start_addr", 16'(start_addr_o), 16'h0);
    check("R1 reset clears h_total", 16'(h_total_o), 16'h0);
    @(negedge clk); rst_ni = 1'b1; lpen_stb_i = 1'b0;
    bus_write(1'b0, 8'd14);
    @(negedge clk); cs_ni = 1'b0; rs_i = 1'b1; rw_i = 1'b1; en_i = 1'b1;
    #1 check("R1 cursor read after reset", 16'(rdata_o), 16'h0);
    @(negedge clk); en_i = 1'b0; cs_ni = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule